// File: doc/BRIEF.md
# Bit-Manipulation Functional Unit

A purely combinational execution unit for a 64-bit core that handles the awkward bit-level operations which take many instructions in software. It produces one 64-bit result from a single 64-bit operand. A 3-bit opcode selects one of five operations: trailing-zero count, leading-zero count, population count, round-up to a power of two, and bit-field extract with repositioning. Population count can count the whole word or count each 32-, 16- or 8-bit lane on its own. Extract takes two field bounds and a left shift amount.

The unit has no clock, no state and no handshake. The result settles in the same cycle as the inputs, so the surrounding pipeline decides where to register it. Because there is no state, there are no states or transitions to list: the opcode acts only as a selector on a final result multiplexer. Each operation has its own sub-module, and all of them work in parallel on the operand.

Top module: `bmu_top`

## Requirements
- R1: With opcode 0, the result is the number of zero bits below the lowest set bit of the operand.
- R2: With opcode 1, the result is the number of zero bits above the highest set bit of the operand.
- R3: For an all-zero operand, opcodes 0 and 1 both return 64.
- R4: With opcode 2 and lane select 0, the result is the number of set bits in the whole 64-bit operand.
- R5: With opcode 2 and lane select 1, 2 or 3 (32-, 16- or 8-bit lanes), each lane of the result holds the set-bit count of the same lane of the operand. The count sits in the lane's low bits, and every higher bit of that lane is zero.
- R6: With opcode 3, the result is the smallest power of two that is not below the operand. A power-of-two operand returns itself.
- R7: With opcode 3, an operand of 0 returns 1, and any operand above 2^63 returns 0.
- R8: With opcode 4, the result is operand bits lo..hi (inclusive), moved down to bit 0 and then shifted left by the shift input. All other result bits are zero.
- R9: With opcode 4, when lo is greater than hi, the two bounds are swapped before use, so the result is the same as with the bounds given in order.
- R10: With opcode 4, field bits that the shift pushes past bit 63 are lost. They do not wrap around and do not appear anywhere in the result.
- R11: Opcodes 5, 6 and 7 return a result of 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 3 | Operation: 0 trailing zeros, 1 leading zeros, 2 popcount, 3 round to power of two, 4 extract |
| lane_sel | input | 2 | Popcount lane size: 0 = 64, 1 = 32, 2 = 16, 3 = 8 bits |
| src | input | 64 | Operand |
| fld_lo | input | 6 | Extract bound (normally the low bit index) |
| fld_hi | input | 6 | Extract bound (normally the high bit index) |
| fld_shift | input | 6 | Left shift applied to the extracted field |
| result | output | 64 | Operation result |

## Verification
The zero counts are driven with a single set bit at every position and with random bits on the far side of that bit. They are also driven with an all-zero operand: a priority encoder that ignores the empty case would report 0 or 63 instead of 64. Round-up is driven at every power of two and at one more and one less than each. An off-by-one in the decrement-and-smear path would double exact powers or miss 0 and the overflow band. Extract is swept over every pair of bounds with several shifts, in both orders. A design that wrapped the shifted field, failed to swap reversed bounds, or miscounted the mask width would corrupt those results. Each popcount lane mode is checked for counts leaking into the upper bits of a lane.

// File: rtl/bmu_pkg.sv
`timescale 1ns/1ps
package bmu_pkg;

    typedef enum logic [2:0] {
        OP_CTZ     = 3'd0,
        OP_CLZ     = 3'd1,
        OP_POPC    = 3'd2,
        OP_RPOW2   = 3'd3,
        OP_EXTRACT = 3'd4
    } bmu_op_e;

    typedef enum logic [1:0] {
        LANE_64 = 2'd0,
        LANE_32 = 2'd1,
        LANE_16 = 2'd2,
        LANE_8  = 2'd3
    } lane_e;

endpackage

// File: rtl/bmu_zcount.sv
`timescale 1ns/1ps
// Counts zero bits from one end of the word up to the first set bit.
// FROM_TOP = 0 counts from bit 0 upward, FROM_TOP = 1 from the MSB downward.
module bmu_zcount #(
    parameter int WIDTH    = 64,
    parameter bit FROM_TOP = 1'b0,
    localparam int IW      = $clog2(WIDTH),
    localparam int CW      = IW + 1
) (
    input  logic [WIDTH-1:0] din,
    output logic [CW-1:0]    count
);

    logic [WIDTH-1:0] oriented;
    logic [WIDTH-1:0] lowest;
    logic [IW-1:0]    idx;

    for (genvar gi = 0; gi < WIDTH; gi++) begin : g_orient
        if (FROM_TOP) begin : g_rev
            assign oriented[gi] = din[WIDTH-1-gi];
        end else begin : g_fwd
            assign oriented[gi] = din[gi];
        end
    end

    // isolate the first set bit, then encode its position
    assign lowest = oriented & (~oriented + WIDTH'(1));

    always_comb begin
        idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (lowest[i]) begin
                idx = idx | IW'(i);
            end
        end
        count = (oriented == '0) ? CW'(WIDTH) : {1'b0, idx};
    end

    // R1 / R2: the bit at the reported count is set and none before it
    always_comb begin
        if (count < CW'(WIDTH)) begin
            a_r1_first_one_found: assert (oriented[count[IW-1:0]] == 1'b1);
            a_r2_nothing_before: assert ((oriented & ((WIDTH'(1) << count) - WIDTH'(1))) == '0);
        end else begin
            a_r3_empty_word: assert (din == '0);
        end
    end

endmodule

// File: rtl/bmu_popcnt.sv
`timescale 1ns/1ps
// Set-bit counting at full width or per 32-, 16- or 8-bit lane.
module bmu_popcnt
    import bmu_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int N8   = WIDTH / 8,
    localparam int N16  = WIDTH / 16,
    localparam int N32  = WIDTH / 32,
    localparam int FW   = $clog2(WIDTH) + 1
) (
    input  logic [WIDTH-1:0] din,
    input  lane_e            lane,
    output logic [WIDTH-1:0] res
);

    logic [3:0]       c8  [N8];
    logic [4:0]       c16 [N16];
    logic [5:0]       c32 [N32];
    logic [FW-1:0]    cfull;
    logic [WIDTH-1:0] r8, r16, r32, r64;

    for (genvar g = 0; g < N8; g++) begin : g_byte
        always_comb begin
            c8[g] = '0;
            for (int b = 0; b < 8; b++) begin
                c8[g] = c8[g] + 4'(din[g*8+b]);
            end
        end
        assign r8[g*8 +: 8] = {4'b0, c8[g]};
    end

    for (genvar g = 0; g < N16; g++) begin : g_half
        assign c16[g] = {1'b0, c8[2*g]} + {1'b0, c8[2*g+1]};
        assign r16[g*16 +: 16] = {11'b0, c16[g]};
    end

    for (genvar g = 0; g < N32; g++) begin : g_word
        assign c32[g] = {1'b0, c16[2*g]} + {1'b0, c16[2*g+1]};
        assign r32[g*32 +: 32] = {26'b0, c32[g]};
    end

    always_comb begin
        cfull = '0;
        for (int k = 0; k < N32; k++) begin
            cfull = cfull + FW'(c32[k]);
        end
    end

    assign r64 = {{(WIDTH-FW){1'b0}}, cfull};

    always_comb begin
        unique case (lane)
            LANE_64: res = r64;
            LANE_32: res = r32;
            LANE_16: res = r16;
            LANE_8:  res = r8;
            default: res = r64;
        endcase
    end

    // R4: the reduction tree agrees with a flat sum of byte counts
    logic [FW-1:0] flat_sum;
    always_comb begin
        flat_sum = '0;
        for (int k = 0; k < N8; k++) begin
            flat_sum = flat_sum + FW'(c8[k]);
        end
        a_r4_tree_matches_flat: assert (flat_sum == cfull);
    end

    // R5: each byte lane count never exceeds the lane size
    always_comb begin
        for (int k = 0; k < N8; k++) begin
            a_r5_byte_bound: assert (c8[k] <= 4'd8);
        end
    end

endmodule

// File: rtl/bmu_pow2.sv
`timescale 1ns/1ps
// Round up to the next power of two by decrement, smear right, increment.
module bmu_pow2 #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] res
);

    logic [WIDTH-1:0] smear;

    always_comb begin
        smear = din - WIDTH'(1);
        for (int s = 1; s < WIDTH; s = s * 2) begin
            smear = smear | (smear >> s);
        end
        res = (din == '0) ? WIDTH'(1) : smear + WIDTH'(1);
    end

    // R6: result is a single bit (or zero on overflow) and never below the input
    always_comb begin
        a_r6_single_bit: assert ($onehot0(res));
        if (res != '0) begin
            a_r6_not_below: assert (res >= din);
        end else begin
            a_r7_overflow_only: assert (din > (WIDTH'(1) << (WIDTH-1)));
        end
    end

endmodule

// File: rtl/bmu_extract.sv
`timescale 1ns/1ps
// Pull an inclusive bit range down to bit 0, then shift it left.
module bmu_extract #(
    parameter int WIDTH = 64,
    localparam int IW   = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] din,
    input  logic [IW-1:0]    bound_a,
    input  logic [IW-1:0]    bound_b,
    input  logic [IW-1:0]    shamt,
    output logic [WIDTH-1:0] res
);

    logic [IW-1:0]    lo, hi, span;
    logic [WIDTH-1:0] mask, field;

    always_comb begin
        if (bound_a <= bound_b) begin
            lo = bound_a;
            hi = bound_b;
        end else begin
            lo = bound_b;
            hi = bound_a;
        end
        span  = hi - lo;
        mask  = {WIDTH{1'b1}} >> (IW'(WIDTH-1) - span);
        field = (din >> lo) & mask;
        res   = field << shamt;
    end

    // R8 / R10: no more bits set than the field holds; nothing below the shift
    always_comb begin
        a_r8_width_bound: assert ($countones(res) <= int'(span) + 1);
        a_r10_low_clear: assert ((res & ((WIDTH'(1) << shamt) - WIDTH'(1))) == '0);
    end

endmodule

// File: rtl/bmu_top.sv
`timescale 1ns/1ps
module bmu_top
    import bmu_pkg::*;
#(
    parameter int WIDTH = 64,
    localparam int IW   = $clog2(WIDTH),
    localparam int CW   = IW + 1
) (
    input  logic [2:0]       op_code,
    input  logic [1:0]       lane_sel,
    input  logic [WIDTH-1:0] src,
    input  logic [IW-1:0]    fld_lo,
    input  logic [IW-1:0]    fld_hi,
    input  logic [IW-1:0]    fld_shift,
    output logic [WIDTH-1:0] result
);

    bmu_op_e          op;
    lane_e            lane;
    logic [CW-1:0]    tz_cnt, lz_cnt;
    logic [WIDTH-1:0] pop_res, pow_res, ext_res;

    assign op   = bmu_op_e'(op_code);
    assign lane = lane_e'(lane_sel);

    bmu_zcount #(.WIDTH(WIDTH), .FROM_TOP(1'b0)) u_tz (
        .din   (src),
        .count (tz_cnt)
    );

    bmu_zcount #(.WIDTH(WIDTH), .FROM_TOP(1'b1)) u_lz (
        .din   (src),
        .count (lz_cnt)
    );

    bmu_popcnt #(.WIDTH(WIDTH)) u_pop (
        .din  (src),
        .lane (lane),
        .res  (pop_res)
    );

    bmu_pow2 #(.WIDTH(WIDTH)) u_pow (
        .din (src),
        .res (pow_res)
    );

    bmu_extract #(.WIDTH(WIDTH)) u_ext (
        .din     (src),
        .bound_a (fld_lo),
        .bound_b (fld_hi),
        .shamt   (fld_shift),
        .res     (ext_res)
    );

    always_comb begin
        unique case (op)
            OP_CTZ:     result = {{(WIDTH-CW){1'b0}}, tz_cnt};
            OP_CLZ:     result = {{(WIDTH-CW){1'b0}}, lz_cnt};
            OP_POPC:    result = pop_res;
            OP_RPOW2:   result = pow_res;
            OP_EXTRACT: result = ext_res;
            default:    result = '0;
        endcase
    end

    // R11: opcodes outside the defined set give zero
    always_comb begin
        if (op_code > 3'd4) begin
            a_r11_spare_zero: assert (result == '0);
        end
    end

    // R3: zero counts saturate at the word width
    always_comb begin
        if (src == '0) begin
            a_r3_zero_counts: assert (tz_cnt == CW'(WIDTH) && lz_cnt == CW'(WIDTH));
        end
    end

endmodule

// File: tb/tb_bmu_top.sv
`timescale 1ns/1ps
module tb_bmu_top;

    logic        clk = 1'b0;
    logic [2:0]  op_code;
    logic [1:0]  lane_sel;
    logic [63:0] src;
    logic [5:0]  fld_lo, fld_hi, fld_shift;
    logic [63:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;
    logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

    always #10 clk = ~clk;

    bmu_top dut (
        .op_code   (op_code),
        .lane_sel  (lane_sel),
        .src       (src),
        .fld_lo    (fld_lo),
        .fld_hi    (fld_hi),
        .fld_shift (fld_shift),
        .result    (result)
    );

    function automatic logic [63:0] next_rand();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 7);
        rng = rng ^ (rng << 17);
        return rng;
    endfunction

    function automatic logic [63:0] ref_tz(logic [63:0] x);
        for (int i = 0; i < 64; i++) if (x[i]) return 64'(i);
        return 64'd64;
    endfunction

    function automatic logic [63:0] ref_lz(logic [63:0] x);
        for (int i = 63; i >= 0; i--) if (x[i]) return 64'(63 - i);
        return 64'd64;
    endfunction

    function automatic logic [63:0] ref_pop(logic [63:0] x, int lane_bits);
        logic [63:0] r = '0;
        for (int base = 0; base < 64; base += lane_bits) begin
            int n = 0;
            for (int b = 0; b < lane_bits; b++) n += int'(x[base+b]);
            r = r | (64'(n) << base);
        end
        return r;
    endfunction

    function automatic logic [63:0] ref_pow(logic [63:0] x);
        if (x == 0) return 64'd1;
        for (int k = 0; k < 64; k++) if ((64'd1 << k) >= x) return 64'd1 << k;
        return 64'd0;
    endfunction

    function automatic logic [63:0] ref_ext(logic [63:0] x, int a, int b, int sh);
        logic [63:0] r = '0;
        int lo = (a < b) ? a : b;
        int hi = (a < b) ? b : a;
        for (int i = lo; i <= hi; i++) begin
            if (i - lo + sh < 64) r[i - lo + sh] = x[i];
        end
        return r;
    endfunction

    task automatic apply(input logic [2:0] op, input logic [1:0] ln, input logic [63:0] x,
                         input logic [5:0] a, input logic [5:0] b, input logic [5:0] sh);
        @(posedge clk);
        #2;
        op_code = op; lane_sel = ln; src = x; fld_lo = a; fld_hi = b; fld_shift = sh;
        #5;
    endtask

    task automatic check(input string req, input logic [63:0] exp);
        checks++;
        if (result !== exp) begin
            errors++;
            $display("FAIL %s: op=%0d src=%h got %h expected %h", req, op_code, src, result, exp);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [63:0] x;
        op_code = 3'd0; lane_sel = 2'd0; src = '0; fld_lo = '0; fld_hi = '0; fld_shift = '0;

        // initial state: all-zero inputs, trailing count of empty word (R3)
        apply(3'd0, 2'd0, 64'd0, 6'd0, 6'd0, 6'd0);
        check("R3", 64'd64);
        apply(3'd1, 2'd0, 64'd0, 6'd0, 6'd0, 6'd0);
        check("R3", 64'd64);

        // R1 / R2: every position, alone and with random bits on the far side
        for (int p = 0; p < 64; p++) begin
            apply(3'd0, 2'd0, 64'd1 << p, 6'd0, 6'd0, 6'd0);
            check("R1", ref_tz(src));
            x = (next_rand() | (64'd1 << p)) & ~((64'd1 << p) - 64'd1);
            apply(3'd0, 2'd0, x, 6'd0, 6'd0, 6'd0);
            check("R1", 64'(p));
            apply(3'd1, 2'd0, 64'd1 << p, 6'd0, 6'd0, 6'd0);
            check("R2", ref_lz(src));
            x = (next_rand() | (64'd1 << p)) & ((64'd1 << p) | ((64'd1 << p) - 64'd1));
            apply(3'd1, 2'd0, x, 6'd0, 6'd0, 6'd0);
            check("R2", 64'(63 - p));
        end

        // R4 / R5: popcount in every lane mode
        for (int n = 0; n < 150; n++) begin
            if (n == 0) x = '0;
            else if (n == 1) x = '1;
            else if (n == 2) x = 64'h8000_0001_FF00_00F0;
            else x = next_rand();
            apply(3'd2, 2'd0, x, 6'd0, 6'd0, 6'd0);
            check("R4", ref_pop(x, 64));
            apply(3'd2, 2'd1, x, 6'd0, 6'd0, 6'd0);
            check("R5", ref_pop(x, 32));
            apply(3'd2, 2'd2, x, 6'd0, 6'd0, 6'd0);
            check("R5", ref_pop(x, 16));
            apply(3'd2, 2'd3, x, 6'd0, 6'd0, 6'd0);
            check("R5", ref_pop(x, 8));
        end

        // R6 / R7: round up around every power of two
        apply(3'd3, 2'd0, 64'd0, 6'd0, 6'd0, 6'd0);
        check("R7", 64'd1);
        apply(3'd3, 2'd0, '1, 6'd0, 6'd0, 6'd0);
        check("R7", 64'd0);
        apply(3'd3, 2'd0, 64'h8000_0000_0000_0001, 6'd0, 6'd0, 6'd0);
        check("R7", 64'd0);
        for (int k = 0; k < 64; k++) begin
            apply(3'd3, 2'd0, 64'd1 << k, 6'd0, 6'd0, 6'd0);
            check("R6", 64'd1 << k);
            apply(3'd3, 2'd0, (64'd1 << k) + 64'd1, 6'd0, 6'd0, 6'd0);
            check(k == 63 ? "R7" : "R6", ref_pow(src));
            apply(3'd3, 2'd0, (64'd1 << k) - 64'd1, 6'd0, 6'd0, 6'd0);
            check("R6", ref_pow(src));
        end
        for (int n = 0; n < 100; n++) begin
            x = next_rand() >> (n % 64);
            apply(3'd3, 2'd0, x, 6'd0, 6'd0, 6'd0);
            check("R6", ref_pow(x));
        end

        // R8 / R9 / R10: every bound pair, both orders, two shifts each
        for (int a = 0; a < 64; a++) begin
            x = next_rand();
            for (int b = 0; b < 64; b++) begin
                int sh = (a * 7 + b * 3) % 64;
                apply(3'd4, 2'd0, x, 6'(a), 6'(b), 6'(sh));
                if (a > b) check("R9", ref_ext(x, a, b, sh));
                else if (b - a + sh >= 64) check("R10", ref_ext(x, a, b, sh));
                else check("R8", ref_ext(x, a, b, sh));
                apply(3'd4, 2'd0, x, 6'(a), 6'(b), 6'd0);
                check(a > b ? "R9" : "R8", ref_ext(x, a, b, 0));
            end
        end
        // R10: full field shifted to the top keeps only bit 0
        apply(3'd4, 2'd0, '1, 6'd0, 6'd63, 6'd63);
        check("R10", 64'h8000_0000_0000_0000);

        // R11: spare opcodes
        for (int o = 5; o < 8; o++) begin
            apply(3'(o), 2'd3, 64'hDEAD_BEEF_0123_4567, 6'd3, 6'd40, 6'd2);
            check("R11", 64'd0);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule